// File: doc/BRIEF.md
# Multi-level priority interrupt controller

This block arbitrates interrupt requests for a small 8-bit processor core. It holds one request flag per source, eleven by default. It chooses among the pending sources that are enabled, using four priority levels. When the core finishes an instruction and the winning request is allowed through, the block tells the core to take a forced call to that source's fixed vector address. Each source has its own enable bit, and a global enable gates all of them. A flag latches whether or not its source is enabled. Two external pins can each be set to trigger on a falling edge or on a low level.

The block keeps one in-service bit for each priority level. A new request is acknowledged only if its level is strictly above every level already in service, so a request at an equal level must wait. A return-from-interrupt clears the highest in-service bit. No acknowledge is issued when the instruction that just completed was a return-from-interrupt or wrote the enable or priority settings. Flags for timer-type sources and for external edge events clear themselves when their interrupt is acknowledged. Software clears the other flags.

Top module: `irq_arbiter`

## Requirements
- R1: A source's request flag (on `irq_pend`) is set one cycle after its `src_set` bit is high, even when its `en_mask` bit or `glb_en` is 0.
- R2: A high `src_clr` bit clears that flag one cycle later. If `src_set` and `src_clr` are both high, the set wins.
- R3: External pin k maps to source 0 for k=0 and source 2 for k=1. With `ext_edge_mode[k]`=1, a falling edge on `ext_pin_n[k]` latches the flag, and the flag stays set after the pin returns high. With `ext_edge_mode[k]`=0, the flag follows the low level of the pin. `src_set` has no effect on these two sources.
- R4: An acknowledge happens only on a cycle with `instr_done`=1. `ack_valid` pulses high for one cycle in the next cycle, together with `ack_src`, `ack_lvl` and `ack_vec`.
- R5: A request is acknowledged only when no `in_svc` bit at its level or above is set. On acknowledge, `in_svc[ack_lvl]` is set.
- R6: No acknowledge is issued for an instruction that completes with `instr_is_reti`=1 or that asserted `cfg_wr`. The next instruction may be acknowledged.
- R7: No acknowledge is issued while `glb_en`=0, or for a source whose `en_mask` bit is 0.
- R8: `ack_vec` equals 0x0003 + 8 × `ack_src`.
- R9: A completing instruction with `instr_is_reti`=1 clears the highest set bit of `in_svc`.
- R10: A source's level is {`prio_hi[i]`,`prio_lo[i]`}, where 3 is the highest. The highest pending level wins, and within one level the lowest source index wins.
- R11: The flags of sources 0 to 3 clear in the acknowledge cycle. The flags of other sources stay set until software clears them.
- R12: After reset, `irq_pend`, `in_svc` and `ack_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| src_set | input | 11 | Per-source request condition pulses (ignored for sources 0 and 2) |
| src_clr | input | 11 | Per-source software clear of request flags |
| ext_pin_n | input | 2 | External request pins, active low |
| ext_edge_mode | input | 2 | Per pin: 1 falling edge, 0 low level |
| en_mask | input | 11 | Per-source enable |
| glb_en | input | 1 | Global enable |
| prio_lo | input | 11 | Low-order priority bit per source |
| prio_hi | input | 11 | High-order priority bit per source |
| instr_done | input | 1 | The current instruction completes this cycle |
| instr_is_reti | input | 1 | The completing instruction is a return-from-interrupt |
| cfg_wr | input | 1 | The current instruction writes the enable or priority settings |
| ack_valid | output | 1 | Forced-call request, a one-cycle pulse |
| ack_src | output | 4 | Acknowledged source index |
| ack_lvl | output | 2 | Acknowledged priority level |
| ack_vec | output | 16 | Vector address to call |
| in_svc | output | 4 | In-service bit per priority level |
| irq_pend | output | 11 | Latched request flags |

## Verification
The hardest state to reach is a stack of nested in-service levels with requests still pending. In that state, a return-from-interrupt uncovers a request that is at the same level as one still in service, or that becomes eligible only one instruction later. Directed sequences build three nested levels one at a time. Each level is raised by a priority write followed by a strictly higher request. The sequences then unwind with returns and check, at each return, that the waiting equal-level request stays blocked until the return after it. Random traffic then mixes sparse requests, clears, configuration writes and returns against a bench model of the flags and the in-service levels.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_N = 4;
  localparam int LVL_W = 2;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [LVL_N-1:0] svc_t;

  // clear the highest set bit of the in-service vector
  function automatic svc_t drop_top(input svc_t v);
    svc_t r;
    logic done;
    r = v;
    done = 1'b0;
    for (int i = LVL_N - 1; i >= 0; i--) begin
      if (!done && v[i]) begin
        r[i] = 1'b0;
        done = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_pin_capture.sv
module irq_pin_capture #(
  parameter int NUM_EXT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXT-1:0] pin_n,
  output logic [NUM_EXT-1:0] fall,
  output logic [NUM_EXT-1:0] low
);
  logic [NUM_EXT-1:0] d1_q, d2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      d1_q <= '1;
      d2_q <= '1;
    end else begin
      d1_q <= pin_n;
      d2_q <= d1_q;
    end
  end

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_pin
    assign fall[k] = d2_q[k] & ~d1_q[k];
    assign low[k]  = ~d1_q[k];
  end
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int                  NUM_SRC  = 11,
  parameter int                  SRC_W    = 4,
  parameter int                  EXT0_SRC = 0,
  parameter int                  EXT1_SRC = 2,
  parameter logic [NUM_SRC-1:0]  AUTO_CLR = 'h00F
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic [NUM_SRC-1:0] src_clr,
  input  logic [1:0]         ext_fall,
  input  logic [1:0]         ext_low,
  input  logic [1:0]         ext_edge_mode,
  input  logic [NUM_SRC-1:0] en_mask,
  input  logic               ack_fire,
  input  logic [SRC_W-1:0]   ack_idx,
  output logic [NUM_SRC-1:0] flags,
  output logic [NUM_SRC-1:0] samp
);
  logic [NUM_SRC-1:0] ack_oh;
  logic [NUM_SRC-1:0] flags_nxt;

  assign ack_oh = ack_fire ? (NUM_SRC'(1) << ack_idx) : '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic keep;
    assign keep = flags[i] & ~src_clr[i] & ~(ack_oh[i] & AUTO_CLR[i]);
    if (i == EXT0_SRC || i == EXT1_SRC) begin : g_ext
      localparam int K = (i == EXT0_SRC) ? 0 : 1;
      assign flags_nxt[i] = ext_edge_mode[K] ? (keep | ext_fall[K]) : ext_low[K];
    end else begin : g_int
      assign flags_nxt[i] = keep | src_set[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      samp  <= '0;
    end else begin
      flags <= flags_nxt;
      // polled copy: enabled requests only, acknowledged one withdrawn
      samp  <= flags & en_mask & ~ack_oh;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 11,
  parameter int SRC_W   = 4
) (
  input  logic [NUM_SRC-1:0] samp,
  input  logic [NUM_SRC-1:0] prio_lo,
  input  logic [NUM_SRC-1:0] prio_hi,
  output logic               cand_v,
  output logic [SRC_W-1:0]   cand_idx,
  output lvl_t               cand_lvl
);
  always_comb begin
    cand_v   = 1'b0;
    cand_idx = '0;
    cand_lvl = '0;
    // descending scan with >= leaves the lowest index on ties
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (samp[i] && (!cand_v || {prio_hi[i], prio_lo[i]} >= cand_lvl)) begin
        cand_v   = 1'b1;
        cand_idx = SRC_W'(i);
        cand_lvl = {prio_hi[i], prio_lo[i]};
      end
    end
  end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
  import irq_pkg::*;
#(
  parameter int          SRC_W    = 4,
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter int          VEC_STEP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_done,
  input  logic              instr_is_reti,
  input  logic              cfg_wr,
  input  logic              glb_en,
  input  logic              cand_v,
  input  logic [SRC_W-1:0]  cand_idx,
  input  lvl_t              cand_lvl,
  output logic              fire,
  output logic              ack_valid,
  output logic [SRC_W-1:0]  ack_src,
  output lvl_t              ack_lvl,
  output logic [ADDR_W-1:0] ack_vec,
  output svc_t              in_svc
);
  logic blk_q;
  logic blocked;
  logic higher_ok;

  assign blocked   = blk_q | cfg_wr | instr_is_reti;
  assign higher_ok = ((in_svc >> cand_lvl) == '0);
  assign fire      = instr_done & ~blocked & glb_en & cand_v & higher_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q     <= 1'b0;
      in_svc    <= '0;
      ack_valid <= 1'b0;
      ack_src   <= '0;
      ack_lvl   <= '0;
      ack_vec   <= '0;
    end else begin
      // a settings write early in a multi-cycle instruction still blocks it
      if (instr_done)  blk_q <= 1'b0;
      else if (cfg_wr) blk_q <= 1'b1;

      ack_valid <= fire;
      if (fire) begin
        ack_src <= cand_idx;
        ack_lvl <= cand_lvl;
        ack_vec <= ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STEP) * ADDR_W'(cand_idx);
        in_svc  <= in_svc | (svc_t'(1) << cand_lvl);
      end else if (instr_done && instr_is_reti) begin
        in_svc  <= drop_top(in_svc);
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int                 NUM_SRC  = 11,
  parameter int                 EXT0_SRC = 0,
  parameter int                 EXT1_SRC = 2,
  parameter logic [NUM_SRC-1:0] AUTO_CLR = 'h00F,
  parameter int                 ADDR_W   = 16,
  parameter logic [15:0]        VEC_BASE = 16'h0003,
  parameter int                 VEC_STEP = 8,
  localparam int                SRC_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic [NUM_SRC-1:0] src_clr,
  input  logic [1:0]         ext_pin_n,
  input  logic [1:0]         ext_edge_mode,
  input  logic [NUM_SRC-1:0] en_mask,
  input  logic               glb_en,
  input  logic [NUM_SRC-1:0] prio_lo,
  input  logic [NUM_SRC-1:0] prio_hi,
  input  logic               instr_done,
  input  logic               instr_is_reti,
  input  logic               cfg_wr,
  output logic               ack_valid,
  output logic [SRC_W-1:0]   ack_src,
  output logic [1:0]         ack_lvl,
  output logic [ADDR_W-1:0]  ack_vec,
  output logic [3:0]         in_svc,
  output logic [NUM_SRC-1:0] irq_pend
);
  logic [1:0]         ext_fall, ext_low;
  logic [NUM_SRC-1:0] samp;
  logic               cand_v, fire;
  logic [SRC_W-1:0]   cand_idx;
  lvl_t               cand_lvl;

  irq_pin_capture #(.NUM_EXT(2)) pins_i (
    .clk(clk), .rst(rst), .pin_n(ext_pin_n), .fall(ext_fall), .low(ext_low)
  );

  irq_req_bank #(
    .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .EXT0_SRC(EXT0_SRC),
    .EXT1_SRC(EXT1_SRC), .AUTO_CLR(AUTO_CLR)
  ) bank_i (
    .clk(clk), .rst(rst), .src_set(src_set), .src_clr(src_clr),
    .ext_fall(ext_fall), .ext_low(ext_low), .ext_edge_mode(ext_edge_mode),
    .en_mask(en_mask), .ack_fire(fire), .ack_idx(cand_idx),
    .flags(irq_pend), .samp(samp)
  );

  irq_pick #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) pick_i (
    .samp(samp), .prio_lo(prio_lo), .prio_hi(prio_hi),
    .cand_v(cand_v), .cand_idx(cand_idx), .cand_lvl(cand_lvl)
  );

  irq_svc_track #(
    .SRC_W(SRC_W), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) svc_i (
    .clk(clk), .rst(rst), .instr_done(instr_done),
    .instr_is_reti(instr_is_reti), .cfg_wr(cfg_wr), .glb_en(glb_en),
    .cand_v(cand_v), .cand_idx(cand_idx), .cand_lvl(cand_lvl),
    .fire(fire), .ack_valid(ack_valid), .ack_src(ack_src),
    .ack_lvl(ack_lvl), .ack_vec(ack_vec), .in_svc(in_svc)
  );
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int          SRC_W    = 4,
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter int          VEC_STEP = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_done,
  input logic              instr_is_reti,
  input logic              cfg_wr,
  input logic              glb_en,
  input logic              ack_valid,
  input logic [SRC_W-1:0]  ack_src,
  input logic [1:0]        ack_lvl,
  input logic [ADDR_W-1:0] ack_vec,
  input logic [3:0]        in_svc
);
  AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> $past(instr_done)); // R4
  AST_ACK_SETS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> in_svc[ack_lvl]); // R5
  AST_ACK_STRICTLY_HIGHER: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> (($past(in_svc) >> ack_lvl) == 4'b0)); // R5
  AST_NO_ACK_AFTER_BLOCKER: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> !$past(instr_is_reti) && !$past(cfg_wr)); // R6
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> $past(glb_en)); // R7
  AST_VECTOR_MAP: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> ack_vec == ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STEP) * ADDR_W'(ack_src)); // R8
  AST_RETI_POPS_ONE: assert property (@(posedge clk) disable iff (rst)
    (instr_done && instr_is_reti && in_svc != 4'b0) |=>
      ($countones(in_svc) + 1 == $countones($past(in_svc)))); // R9
endmodule

bind irq_arbiter irq_arbiter_chk #(
  .SRC_W(SRC_W), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) chk_i (
  .clk(clk), .rst(rst), .instr_done(instr_done), .instr_is_reti(instr_is_reti),
  .cfg_wr(cfg_wr), .glb_en(glb_en), .ack_valid(ack_valid), .ack_src(ack_src),
  .ack_lvl(ack_lvl), .ack_vec(ack_vec), .in_svc(in_svc)
);

// File: tb/irq_arbiter_tb_top.sv
module irq_arbiter_tb_top;
  localparam int N = 11;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] src_set = '0, src_clr = '0, en_mask = '0, prio_lo = '0, prio_hi = '0;
  logic [1:0] ext_pin_n = 2'b11, ext_edge_mode = 2'b11;
  logic glb_en = 1'b0, instr_done = 1'b0, instr_is_reti = 1'b0, cfg_wr = 1'b0;
  logic ack_valid;
  logic [3:0] ack_src, in_svc;
  logic [1:0] ack_lvl;
  logic [15:0] ack_vec;
  logic [N-1:0] irq_pend;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  irq_arbiter dut_i (
    .clk(clk), .rst(rst), .src_set(src_set), .src_clr(src_clr),
    .ext_pin_n(ext_pin_n), .ext_edge_mode(ext_edge_mode), .en_mask(en_mask),
    .glb_en(glb_en), .prio_lo(prio_lo), .prio_hi(prio_hi),
    .instr_done(instr_done), .instr_is_reti(instr_is_reti), .cfg_wr(cfg_wr),
    .ack_valid(ack_valid), .ack_src(ack_src), .ack_lvl(ack_lvl),
    .ack_vec(ack_vec), .in_svc(in_svc), .irq_pend(irq_pend)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pulse set/clear for one cycle, then let flags reach the polled copy
  task automatic pulse(input logic [N-1:0] s, input logic [N-1:0] c);
    src_set = s; src_clr = c;
    @(negedge clk);
    src_set = '0; src_clr = '0;
    idle(2);
  endtask

  // one completing instruction; outputs are valid at the returning negedge
  task automatic instr(input bit reti, input bit wr);
    instr_done = 1'b1; instr_is_reti = reti; cfg_wr = wr;
    @(negedge clk);
    instr_done = 1'b0; instr_is_reti = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic expect_ack(input string req, input int src, input int lvl, input int svc);
    chk(ack_valid === 1'b1, req, "ack_valid", int'(ack_valid), 1);
    chk(ack_src == 4'(src), req, "ack_src", int'(ack_src), src);
    chk(ack_lvl == 2'(lvl), req, "ack_lvl", int'(ack_lvl), lvl);
    chk(ack_vec == 16'(3 + 8 * src), "R8", "ack_vec", int'(ack_vec), 3 + 8 * src);
    chk(in_svc == 4'(svc), req, "in_svc", int'(in_svc), svc);
  endtask

  task automatic expect_none(input string req, input int svc);
    chk(ack_valid === 1'b0, req, "ack_valid", int'(ack_valid), 0);
    chk(in_svc == 4'(svc), req, "in_svc", int'(in_svc), svc);
  endtask

  function automatic int model_pick(input logic [N-1:0] f, input logic [N-1:0] en,
                                    input logic [N-1:0] lo, input logic [N-1:0] hi);
    int best = -1;
    int bl = -1;
    for (int i = 0; i < N; i++)
      if (f[i] && en[i] && int'({hi[i], lo[i]}) > bl) begin
        best = i; bl = int'({hi[i], lo[i]});
      end
    return best;
  endfunction

  function automatic logic [3:0] model_pop(input logic [3:0] v);
    for (int i = 3; i >= 0; i--) if (v[i]) begin v[i] = 1'b0; return v; end
    return v;
  endfunction

  initial begin
    logic [N-1:0] m_flags;
    logic [3:0] m_svc;
    void'($urandom(32'h1234_5678));
    idle(3);
    rst = 1'b0;
    idle(1);
    // R12: reset state
    chk(irq_pend == '0, "R12", "irq_pend", int'(irq_pend), 0);
    expect_none("R12", 0);

    // R1: flag latches while disabled; R7: disabled source not acknowledged
    pulse(N'(1) << 5, '0);
    chk(irq_pend[5] === 1'b1, "R1", "flag5", int'(irq_pend[5]), 1);
    instr(0, 0);
    expect_none("R7", 0);

    // R7: global enable off blocks everything
    en_mask = '1; glb_en = 1'b0; instr(0, 1); idle(2);
    instr(0, 0);
    expect_none("R7", 0);

    // R6: settings write blocks that instruction, next one is acknowledged
    glb_en = 1'b1; instr(0, 1);
    expect_none("R6", 0);
    idle(1);
    instr(0, 0);
    expect_ack("R4", 5, 0, 4'b0001);
    idle(1);
    chk(irq_pend[5] === 1'b1, "R11", "flag5 kept", int'(irq_pend[5]), 1);
    pulse('0, N'(1) << 5);
    chk(irq_pend[5] === 1'b0, "R2", "flag5 cleared", int'(irq_pend[5]), 0);
    pulse(N'(1) << 6, N'(1) << 6);
    chk(irq_pend[6] === 1'b1, "R2", "set wins", int'(irq_pend[6]), 1);
    pulse('0, N'(1) << 6);

    // R5: equal level blocked
    pulse(N'(1) << 7, '0);
    instr(0, 0);
    expect_none("R5", 4'b0001);

    // R5: nested preemption, level 2 then level 3
    prio_hi[9] = 1'b1; instr(0, 1); idle(2);
    pulse(N'(1) << 9, '0);
    instr(0, 0);
    expect_ack("R5", 9, 2, 4'b0101);
    prio_hi[1] = 1'b1; prio_lo[1] = 1'b1; instr(0, 1); idle(2);
    pulse(N'(1) << 1, '0);
    instr(0, 0);
    expect_ack("R5", 1, 3, 4'b1101);
    chk(irq_pend[1] === 1'b0, "R11", "timer flag auto-cleared", int'(irq_pend[1]), 0);

    // R9: returns unwind levels; R6 return blocks the waiting request
    idle(1); instr(1, 0);
    expect_none("R9", 4'b0101);
    pulse('0, N'(1) << 9);
    instr(1, 0);
    expect_none("R9", 4'b0001);
    idle(1); instr(0, 0);
    expect_none("R5", 4'b0001);
    idle(1); instr(1, 0);
    expect_none("R6", 4'b0000);
    idle(1); instr(0, 0);
    expect_ack("R4", 7, 0, 4'b0001);
    idle(1); instr(1, 0);
    pulse('0, '1);

    // R10: highest level wins, lowest index on ties
    prio_lo = '0; prio_hi = '0;
    prio_lo[4] = 1'b1; prio_lo[6] = 1'b1; prio_lo[8] = 1'b1;
    instr(0, 1); idle(2);
    pulse((N'(1) << 4) | (N'(1) << 6) | (N'(1) << 8) | (N'(1) << 10), '0);
    instr(0, 0);
    expect_ack("R10", 4, 1, 4'b0010);
    idle(1); instr(1, 0);
    pulse('0, '1);
    prio_lo = '0; instr(0, 1); idle(2);

    // R3: falling edge latches, low level follows pin
    ext_edge_mode = 2'b01;
    ext_pin_n[0] = 1'b0; idle(4);
    chk(irq_pend[0] === 1'b1, "R3", "edge flag", int'(irq_pend[0]), 1);
    ext_pin_n[0] = 1'b1; idle(4);
    chk(irq_pend[0] === 1'b1, "R3", "edge flag held", int'(irq_pend[0]), 1);
    pulse(N'(1) << 2, '0);
    chk(irq_pend[2] === 1'b0, "R3", "set ignored on pin source", int'(irq_pend[2]), 0);
    ext_pin_n[1] = 1'b0; idle(4);
    chk(irq_pend[2] === 1'b1, "R3", "level flag low", int'(irq_pend[2]), 1);
    ext_pin_n[1] = 1'b1; idle(4);
    chk(irq_pend[2] === 1'b0, "R3", "level flag released", int'(irq_pend[2]), 0);
    instr(0, 0);
    expect_ack("R8", 0, 0, 4'b0001);
    chk(irq_pend[0] === 1'b0, "R11", "edge flag auto-cleared", int'(irq_pend[0]), 0);
    idle(1); instr(1, 0);
    ext_edge_mode = 2'b11;
    pulse('0, '1);

    // random phase against model
    m_flags = '0; m_svc = '0;
    for (int it = 0; it < 400; it++) begin
      logic [N-1:0] s, c;
      if ($urandom_range(7) == 0) begin
        en_mask = N'($urandom); prio_lo = N'($urandom); prio_hi = N'($urandom);
        glb_en = ($urandom_range(4) != 0);
        instr(0, 1);
        expect_none("R6", int'(m_svc));
        idle(2);
      end
      s = N'($urandom & $urandom & $urandom) & ~N'(5);
      c = N'($urandom & $urandom);
      m_flags = (m_flags & ~c) | s;
      pulse(s, c);
      if ($urandom_range(3) == 0) begin
        instr(1, 0);
        m_svc = model_pop(m_svc);
        expect_none("R9", int'(m_svc));
      end else begin
        int w;
        instr(0, 0);
        w = model_pick(m_flags, en_mask, prio_lo, prio_hi);
        if (glb_en && w >= 0 && ((m_svc >> {prio_hi[w], prio_lo[w]}) == 4'b0)) begin
          m_svc[{prio_hi[w], prio_lo[w]}] = 1'b1;
          if (w < 4) m_flags[w] = 1'b0;
          expect_ack("R10", w, int'({prio_hi[w], prio_lo[w]}), int'(m_svc));
        end else begin
          expect_none("R5", int'(m_svc));
        end
      end
      chk(irq_pend == m_flags, "R1", "irq_pend", int'(irq_pend), int'(m_flags));
    end

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule